// File: doc/BRIEF.md
# Pulse-Position Reader Command Decoder

This block sits behind the demodulator of a contactless tag front end. It watches a one-bit signal that goes high while the reader pauses its carrier, and it turns the pause positions into command bytes. The timebase is one clock per tick. A slot is 8 ticks, and a pause is recognised by its rising edge. Two codings are supported. In the fast one, a 32-tick symbol holds one pause in one of 4 slots and so carries 2 bits, and a byte takes 128 ticks. In the slow one, a 2048-tick symbol holds one pause in one of 256 slots and so carries a whole byte. The spacing of the start-of-frame pauses tells the block which coding the reader has chosen, so no configuration is needed.

Each decoded byte is presented with a one-cycle strobe. When the end-of-frame pattern completes, the block raises a done strobe. With it come the tick at which the frame ended, the byte count, the coding, and a start-of-frame tick. The start tick is computed back from the end tick, the byte count and the coding. A pause that falls off the slot grid ends the frame with a grid error. So does a missing pause. A frame longer than the byte limit ends with an overflow error.

The controller has five states. IDLE waits for a first pause edge and moves to SOF_GAP. SOF_GAP waits for the second start-of-frame edge: at 24 ticks it picks fast coding, at 16 ticks slow coding, and in both cases moves to SOF_TAIL. Any other spacing returns the block to IDLE with a grid error. SOF_TAIL idles until tick 32 of the frame and then moves to DATA. DATA collects one pause per symbol. A pause at a byte boundary moves it to EOF_TAIL, and any violation sends it back to IDLE. EOF_TAIL counts 16 ticks, reports the frame and returns to IDLE.

Top module: `ppm_cmd_decoder`

## Requirements
- R1: After reset, active_o, byte_vld_o, frame_done_o, err_grid_o and err_ovf_o are all 0.
- R2: In fast coding, a pause edge at tick 8k+4 of a 32-tick symbol (k = 0..3) carries the two-bit value k. Four symbols form a byte, least significant pair first. The byte appears on byte_o with byte_vld_o high for one cycle, one cycle after the byte's last tick.
- R3: In slow coding, a pause edge at tick 8k+4 of a 2048-tick symbol (k = 0..255) yields byte value k with a one-cycle byte_vld_o.
- R4: Data begins 32 ticks after the first start-of-frame edge. A second edge 24 ticks after the first selects fast coding (slow_coding_o = 0). A second edge 16 ticks after the first selects slow coding (slow_coding_o = 1). Any other second edge, or none by tick 24, raises err_grid_o for one cycle and returns the block to IDLE.
- R5: A pause edge at tick 0 of a symbol that starts a byte is the end of frame. 16 ticks later frame_done_o pulses for one cycle. eof_time_o then holds the free-running tick count (0 at reset, +1 per clock) of that 16th tick, and byte_count_o holds the number of bytes delivered.
- R6: At frame_done_o, sof_time_o equals eof_time_o − byte_count_o × (128 fast, 2048 slow) − 32 − 16. This is the tick of the first start-of-frame edge.
- R7: Each of the following raises err_grid_o for one cycle, returns to IDLE and emits no byte: a pause edge off the 8k+4 grid, a second pause in one symbol, a symbol without a pause, an end-of-frame edge inside a byte, or any edge in SOF_TAIL or EOF_TAIL.
- R8: When a byte completes while MAX_BYTES bytes have already been delivered, the byte is not emitted. err_ovf_o pulses for one cycle, the block returns to IDLE, and byte_count_o stays at MAX_BYTES.
- R9: active_o is high from the cycle after the first start-of-frame edge until the frame ends by done or by error. It is low in the cycle where frame_done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| pause_i | input | 1 | High while the reader carrier is paused |
| byte_vld_o | output | 1 | One-cycle strobe for a decoded byte |
| byte_o | output | 8 | Decoded byte |
| frame_done_o | output | 1 | One-cycle strobe at end of frame |
| eof_time_o | output | TIME_W | Tick at which the end of frame completed |
| sof_time_o | output | TIME_W | Computed tick of the frame start |
| byte_count_o | output | CNT_W | Bytes delivered in the current or last frame |
| slow_coding_o | output | 1 | 1 for 1-of-256 coding, 0 for 1-of-4 |
| active_o | output | 1 | Frame in progress |
| err_grid_o | output | 1 | One-cycle strobe when a frame is dropped for bad timing |
| err_ovf_o | output | 1 | One-cycle strobe when a frame is dropped for exceeding MAX_BYTES |

## Verification
The symbol position counter and the pair index decide every result. If either is off by a tick, the next pause falls off the grid and err_grid_o appears in that same frame. A pair index that is wrong but still in step instead shows up as a wrong byte_o value at the first byte strobe. A wrong byte counter or coding flag stays hidden until frame_done_o, where sof_time_o no longer matches the tick of the first pause. The scoreboard compares every strobe in order, so a missing or extra byte is reported at the next event of the frame.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
    localparam int SLOT_TICKS      = 8;
    localparam int PAUSE_PHASE     = 4;
    localparam int SOF_TICKS       = 32;
    localparam int EOF_TICKS       = 16;
    localparam int SOF_FAST_GAP    = 24;
    localparam int SOF_SLOW_GAP    = 16;
    localparam int FAST_SYM_TICKS  = 32;
    localparam int SLOW_SYM_TICKS  = 2048;
    localparam int FAST_BYTE_TICKS = 128;
    localparam int SLOW_BYTE_TICKS = 2048;
    localparam int FAST_SHIFT      = $clog2(FAST_BYTE_TICKS);
    localparam int SLOW_SHIFT      = $clog2(SLOW_BYTE_TICKS);
    localparam int FRAME_OVERHEAD  = SOF_TICKS + EOF_TICKS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF_GAP,
        ST_SOF_TAIL,
        ST_DATA,
        ST_EOF_TAIL
    } dec_state_e;

    typedef enum logic {
        CODE_FAST = 1'b0,
        CODE_SLOW = 1'b1
    } coding_e;
endpackage

// File: rtl/ppm_edge.sv
module ppm_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    // Held high in reset so a pause present at release is not an edge.
    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b1;
        else     level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/ppm_timebase.sv
module ppm_timebase #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TIME_W-1:0] now_o
);
    always_ff @(posedge clk) begin
        if (rst) now_o <= '0;
        else     now_o <= now_o + 1'b1;
    end
endmodule

// File: rtl/ppm_stamp.sv
module ppm_stamp #(
    parameter int TIME_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic [TIME_W-1:0] end_tick_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              slow_i,
    output logic [TIME_W-1:0] start_tick_o
);
    import ppm_pkg::*;

    logic [TIME_W-1:0] data_span;
    logic [TIME_W-1:0] count_w;

    assign count_w      = TIME_W'(count_i);
    assign data_span    = slow_i ? (count_w << SLOW_SHIFT) : (count_w << FAST_SHIFT);
    assign start_tick_o = end_tick_i - data_span - TIME_W'(FRAME_OVERHEAD);
endmodule

// File: rtl/ppm_cmd_decoder.sv
module ppm_cmd_decoder #(
    parameter int TIME_W    = 32,
    parameter int MAX_BYTES = 32,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pause_i,
    output logic              byte_vld_o,
    output logic [7:0]        byte_o,
    output logic              frame_done_o,
    output logic [TIME_W-1:0] eof_time_o,
    output logic [TIME_W-1:0] sof_time_o,
    output logic [CNT_W-1:0]  byte_count_o,
    output logic              slow_coding_o,
    output logic              active_o,
    output logic              err_grid_o,
    output logic              err_ovf_o
);
    import ppm_pkg::*;

    localparam int POS_W = $clog2(SLOW_SYM_TICKS);
    localparam int OFS_W = $clog2(SOF_TICKS) + 1;
    localparam int PH_W  = $clog2(SLOT_TICKS);

    dec_state_e        state_q, state_d;
    coding_e           coding_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [POS_W-1:0]  pos_q;
    logic              got_q;
    logic [7:0]        slot_q;
    logic [1:0]        pair_q;
    logic [7:0]        asm_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              rise;
    logic [TIME_W-1:0] now;
    logic [TIME_W-1:0] sof_calc;

    ppm_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (pause_i),
        .rise_o  (rise)
    );

    ppm_timebase #(.TIME_W(TIME_W)) u_time (
        .clk   (clk),
        .rst   (rst),
        .now_o (now)
    );

    ppm_stamp #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_stamp (
        .end_tick_i   (now),
        .count_i      (cnt_q),
        .slow_i       (coding_q == CODE_SLOW),
        .start_tick_o (sof_calc)
    );

    logic [POS_W-1:0] sym_last;
    logic             on_grid;
    logic [7:0]       slot_idx;
    logic [7:0]       byte_full;
    logic             byte_ends;

    assign sym_last  = (coding_q == CODE_SLOW) ? POS_W'(SLOW_SYM_TICKS - 1)
                                               : POS_W'(FAST_SYM_TICKS - 1);
    assign on_grid   = (pos_q[PH_W-1:0] == PH_W'(PAUSE_PHASE));
    assign slot_idx  = pos_q[POS_W-1:PH_W];
    assign byte_ends = (coding_q == CODE_SLOW) || (pair_q == 2'd3);
    assign byte_full = (coding_q == CODE_SLOW) ? slot_q
                     : (asm_q | ({6'b0, slot_q[1:0]} << {pair_q, 1'b0}));

    // Actions chosen by the transition logic.
    logic    a_start, a_code, a_take, a_commit, a_emit;
    logic    a_ovf, a_grid, a_eof, a_done, a_enter_data;
    coding_e code_sel;

    always_comb begin
        state_d      = state_q;
        a_start      = 1'b0;
        a_code       = 1'b0;
        code_sel     = CODE_FAST;
        a_take       = 1'b0;
        a_commit     = 1'b0;
        a_emit       = 1'b0;
        a_ovf        = 1'b0;
        a_grid       = 1'b0;
        a_eof        = 1'b0;
        a_done       = 1'b0;
        a_enter_data = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rise) begin
                    a_start = 1'b1;
                    state_d = ST_SOF_GAP;
                end
            end
            ST_SOF_GAP: begin
                if (rise && ofs_q == OFS_W'(SOF_FAST_GAP)) begin
                    a_code   = 1'b1;
                    code_sel = CODE_FAST;
                    state_d  = ST_SOF_TAIL;
                end else if (rise && ofs_q == OFS_W'(SOF_SLOW_GAP)) begin
                    a_code   = 1'b1;
                    code_sel = CODE_SLOW;
                    state_d  = ST_SOF_TAIL;
                end else if (rise || ofs_q == OFS_W'(SOF_FAST_GAP)) begin
                    a_grid  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_SOF_TAIL: begin
                if (rise) begin
                    a_grid  = 1'b1;
                    state_d = ST_IDLE;
                end else if (ofs_q == OFS_W'(SOF_TICKS - 1)) begin
                    a_enter_data = 1'b1;
                    state_d      = ST_DATA;
                end
            end
            ST_DATA: begin
                if (rise) begin
                    if (pos_q == '0 && pair_q == 2'd0) begin
                        a_eof   = 1'b1;
                        state_d = ST_EOF_TAIL;
                    end else if (on_grid && !got_q) begin
                        a_take = 1'b1;
                    end else begin
                        a_grid  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end else if (pos_q == sym_last) begin
                    if (!got_q) begin
                        a_grid  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        a_commit = 1'b1;
                        if (byte_ends) begin
                            if (cnt_q == CNT_W'(MAX_BYTES)) begin
                                a_ovf   = 1'b1;
                                state_d = ST_IDLE;
                            end else begin
                                a_emit = 1'b1;
                            end
                        end
                    end
                end
            end
            ST_EOF_TAIL: begin
                if (rise) begin
                    a_grid  = 1'b1;
                    state_d = ST_IDLE;
                end else if (ofs_q == OFS_W'(EOF_TICKS)) begin
                    a_done  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Frame datapath: tick offsets, symbol position and byte assembly.
    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q    <= '0;
            pos_q    <= '0;
            got_q    <= 1'b0;
            slot_q   <= '0;
            pair_q   <= '0;
            asm_q    <= '0;
            cnt_q    <= '0;
            coding_q <= CODE_FAST;
        end else begin
            if (a_start) begin
                ofs_q <= OFS_W'(1);
                cnt_q <= '0;
            end else if (a_eof) begin
                ofs_q <= OFS_W'(1);
            end else if (state_q == ST_SOF_GAP || state_q == ST_SOF_TAIL ||
                         state_q == ST_EOF_TAIL) begin
                ofs_q <= ofs_q + 1'b1;
            end

            if (a_code) coding_q <= code_sel;

            if (a_enter_data) begin
                pos_q  <= '0;
                got_q  <= 1'b0;
                pair_q <= '0;
                asm_q  <= '0;
            end else if (state_q == ST_DATA) begin
                pos_q <= (pos_q == sym_last) ? '0 : pos_q + 1'b1;
                if (a_take) begin
                    got_q  <= 1'b1;
                    slot_q <= slot_idx;
                end else if (pos_q == sym_last) begin
                    got_q <= 1'b0;
                end
            end

            if (a_commit) begin
                if (byte_ends) begin
                    pair_q <= '0;
                    asm_q  <= '0;
                end else begin
                    pair_q <= pair_q + 1'b1;
                    asm_q  <= byte_full;
                end
            end

            if (a_emit) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            byte_vld_o   <= 1'b0;
            byte_o       <= '0;
            frame_done_o <= 1'b0;
            eof_time_o   <= '0;
            sof_time_o   <= '0;
            err_grid_o   <= 1'b0;
            err_ovf_o    <= 1'b0;
        end else begin
            byte_vld_o   <= a_emit;
            frame_done_o <= a_done;
            err_grid_o   <= a_grid;
            err_ovf_o    <= a_ovf;
            if (a_emit) byte_o <= byte_full;
            if (a_done) begin
                eof_time_o <= now;
                sof_time_o <= sof_calc;
            end
        end
    end

    assign byte_count_o  = cnt_q;
    assign slow_coding_o = (coding_q == CODE_SLOW);
    assign active_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/ppm_cmd_decoder_chk.sv
module ppm_cmd_decoder_chk #(
    parameter int TIME_W    = 32,
    parameter int MAX_BYTES = 32,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              byte_vld_o,
    input logic              frame_done_o,
    input logic [TIME_W-1:0] eof_time_o,
    input logic [TIME_W-1:0] sof_time_o,
    input logic [CNT_W-1:0]  byte_count_o,
    input logic              slow_coding_o,
    input logic              active_o,
    input logic              err_grid_o,
    input logic              err_ovf_o
);
    logic [TIME_W-1:0] span_exp;
    assign span_exp = TIME_W'(byte_count_o) * (slow_coding_o ? TIME_W'(2048) : TIME_W'(128))
                    + TIME_W'(48);

    // R7: at most one strobe per cycle
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({byte_vld_o, frame_done_o, err_grid_o, err_ovf_o}));

    // R2: bytes only inside a frame
    p_byte_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |-> active_o);

    // R9: frame is closed when done is reported
    p_done_closed_r9: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> !active_o);

    // R6: start stamp lies the frame length before the end stamp
    p_stamp_gap_r6: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> (eof_time_o - sof_time_o) == span_exp);

    // R8: overflow only at the byte limit
    p_ovf_at_limit_r8: assert property (@(posedge clk) disable iff (rst)
        err_ovf_o |-> byte_count_o == CNT_W'(MAX_BYTES));

    // R8: the count never exceeds the limit
    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        byte_count_o <= CNT_W'(MAX_BYTES));

    // R5: a done strobe lasts a single cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |=> !frame_done_o);
endmodule

bind ppm_cmd_decoder ppm_cmd_decoder_chk #(.TIME_W(TIME_W), .MAX_BYTES(MAX_BYTES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .byte_vld_o    (byte_vld_o),
    .frame_done_o  (frame_done_o),
    .eof_time_o    (eof_time_o),
    .sof_time_o    (sof_time_o),
    .byte_count_o  (byte_count_o),
    .slow_coding_o (slow_coding_o),
    .active_o      (active_o),
    .err_grid_o    (err_grid_o),
    .err_ovf_o     (err_ovf_o)
);

// File: tb/ppm_cmd_decoder_test.sv
module ppm_cmd_decoder_test;
    localparam int TW   = 32;
    localparam int MAXB = 4;
    localparam int CW   = $clog2(MAXB + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pause = 1'b0;
    logic          byte_vld, frame_done, slow_coding, active, err_grid, err_ovf;
    logic [7:0]    byte_d;
    logic [TW-1:0] eof_time, sof_time;
    logic [CW-1:0] byte_count;

    ppm_cmd_decoder #(.TIME_W(TW), .MAX_BYTES(MAXB)) uut (
        .clk           (clk),
        .rst           (rst),
        .pause_i       (pause),
        .byte_vld_o    (byte_vld),
        .byte_o        (byte_d),
        .frame_done_o  (frame_done),
        .eof_time_o    (eof_time),
        .sof_time_o    (sof_time),
        .byte_count_o  (byte_count),
        .slow_coding_o (slow_coding),
        .active_o      (active),
        .err_grid_o    (err_grid),
        .err_ovf_o     (err_ovf)
    );

    always #4 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Scoreboard: kind 0 byte, 1 done, 2 grid error, 3 overflow
    int          q_kind[$];
    int unsigned q_a[$];
    int unsigned q_b[$];
    int unsigned q_c[$];

    task automatic check(input bit ok, input string req, input int unsigned act,
                         input int unsigned exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(input int k, input int unsigned a, input int unsigned b,
                             input int unsigned c);
        q_kind.push_back(k);
        q_a.push_back(a);
        q_b.push_back(b);
        q_c.push_back(c);
    endtask

    task automatic pop_check(input int k, input string req, input int unsigned a,
                             input int unsigned b, input int unsigned c);
        int          ek;
        int unsigned ea, eb, ec;
        if (q_kind.size() == 0) begin
            check(1'b0, req, k, 99);
            return;
        end
        ek = q_kind.pop_front();
        ea = q_a.pop_front();
        eb = q_b.pop_front();
        ec = q_c.pop_front();
        check(ek == k, req, k, ek);
        if (ek == k && k == 0) check(a == ea, "R2/R3 byte value", a, ea);
        if (ek == k && k == 1) begin
            check(a == ea, "R6 sof_time", a, ea);
            check(b == eb, "R5 eof_time", b, eb);
            check(c == ec, "R5 byte_count/R4 coding", c, ec);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_vld)   pop_check(0, "R2 byte strobe", byte_d, 0, 0);
            if (frame_done) pop_check(1, "R5 frame done", sof_time, eof_time,
                                      {15'd0, slow_coding, 16'(byte_count)});
            if (err_grid)   pop_check(2, "R7 grid error", 0, 0, 0);
            if (err_ovf)    pop_check(3, "R8 overflow", 0, 0, 0);
        end
    end

    // Driver
    int unsigned cur = 0;
    int unsigned t0  = 0;

    task automatic pulse_at(input int unsigned off);
        repeat (off - cur) @(negedge clk);
        if (off == 0) t0 = cyc;
        pause = 1'b1;
        repeat (2) @(negedge clk);
        pause = 1'b0;
        cur = off + 2;
    endtask

    task automatic quiet(input int n);
        pause = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_frame(input bit slow);
        cur = 0;
        pulse_at(0);
        check(active == 1'b1, "R9 active in frame", active, 1);
        pulse_at(slow ? 16 : 24);
    endtask

    function automatic int unsigned sym_base(input bit slow, input int bidx);
        return 32 + bidx * (slow ? 2048 : 128);
    endfunction

    task automatic send_byte(input bit slow, input int bidx, input logic [7:0] b,
                             input bit push);
        if (push) expect_ev(0, b, 0, 0);
        if (slow) pulse_at(sym_base(1, bidx) + b * 8 + 4);
        else
            for (int k = 0; k < 4; k++)
                pulse_at(sym_base(0, bidx) + k * 32 + ((b >> (2 * k)) & 2'b11) * 8 + 4);
    endtask

    task automatic end_frame(input bit slow, input int n);
        int unsigned eof_exp;
        eof_exp = t0 + 32 + n * (slow ? 2048 : 128) + 16;
        expect_ev(1, t0, eof_exp, {15'd0, slow, 16'(n)});
        pulse_at(sym_base(slow, n));
        quiet(20);
        check(active == 1'b0, "R9 idle after done", active, 0);
    endtask

    task automatic abort_wait(input string req);
        quiet(60);
        check(active == 1'b0, req, active, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(active == 0, "R1 active", active, 0);
        check(byte_vld == 0, "R1 byte_vld", byte_vld, 0);
        check(frame_done == 0, "R1 frame_done", frame_done, 0);
        check(err_grid == 0 && err_ovf == 0, "R1 errors", {err_grid, err_ovf}, 0);
        quiet(5);

        // R2 R4 R5 R6: fast coding, three bytes
        begin_frame(0);
        send_byte(0, 0, 8'hA5, 1);
        send_byte(0, 1, 8'h3C, 1);
        send_byte(0, 2, 8'hE1, 1);
        end_frame(0, 3);
        quiet(10);

        // R3 R4 R6: slow coding, two bytes at both slot extremes
        begin_frame(1);
        send_byte(1, 0, 8'hFF, 1);
        send_byte(1, 1, 8'h00, 1);
        end_frame(1, 2);
        quiet(10);

        // R5 R6: empty fast frame
        begin_frame(0);
        end_frame(0, 0);
        quiet(10);

        // R7: pause off the slot grid
        begin_frame(0);
        expect_ev(2, 0, 0, 0);
        pulse_at(32 + 2);
        abort_wait("R7 off-grid idle");

        // R4: wrong start-of-frame spacing
        cur = 0;
        pulse_at(0);
        expect_ev(2, 0, 0, 0);
        pulse_at(20);
        abort_wait("R4 bad SOF idle");

        // R7: symbol without a pause
        begin_frame(0);
        expect_ev(2, 0, 0, 0);
        abort_wait("R7 missing pause idle");

        // R7: end of frame inside a byte
        begin_frame(0);
        send_byte(0, 0, 8'h12, 1);
        pulse_at(sym_base(0, 1) + 0 * 32 + 1 * 8 + 4);
        pulse_at(sym_base(0, 1) + 1 * 32 + 2 * 8 + 4);
        expect_ev(2, 0, 0, 0);
        pulse_at(sym_base(0, 1) + 2 * 32);
        abort_wait("R7 mid-byte EOF idle");

        // R7: second pause in one symbol
        begin_frame(0);
        pulse_at(32 + 4);
        expect_ev(2, 0, 0, 0);
        pulse_at(32 + 12);
        abort_wait("R7 double pause idle");

        // R8: one byte beyond the limit
        begin_frame(0);
        for (int i = 0; i < MAXB; i++) send_byte(0, i, 8'(8'h40 + i), 1);
        expect_ev(3, 0, 0, 0);
        send_byte(0, MAXB, 8'h77, 0);
        abort_wait("R8 overflow idle");
        check(byte_count == CW'(MAXB), "R8 count held", byte_count, MAXB);

        // R2 R5: a frame still decodes after the errors
        begin_frame(0);
        send_byte(0, 0, 8'h9C, 1);
        end_frame(0, 1);

        quiet(10);
        check(q_kind.size() == 0, "R5 all events seen", q_kind.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule